// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low-Power-Idle Controller

This block decides when the transmit side of an Ethernet MAC may put the link into low-power idle (LPI), and when it must come back out. Software arms the block with two control bits, reports the PHY link state through a third, and can allow the transmit clock to be gated while the link sleeps. A single timer word carries two limits: how long the link must have been reported good before the first entry, counted in millisecond ticks, and how long transmission stays held after the LPI pattern stops, counted in microsecond ticks.

The transmit path tells the block whether it has anything to send. When the block is armed, the link has been good long enough and the path is idle, the block raises its LPI request toward the PHY interface and stalls the data path. New traffic, a lost link or disarming starts a wake. The block then drops the request, keeps the stall for the programmed wake time and releases it. Two sticky flags record LPI entry and LPI exit until software reads them.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: After reset `lpi_req`, `tx_stall`, `clk_gate_en`, `stat_entry` and `stat_exit` are all 0.
- R2: `lpi_req` rises only when `cfg_lpi_en`, `cfg_auto_en`, `cfg_link_up` and `tx_idle` are all 1 and at least N `ms_tick` pulses have been seen since `cfg_link_up` last went to 1, where N is `cfg_timer[25:16]`; N = 0 needs no tick.
- R3: `cfg_link_up` = 0 clears the millisecond count, blocks entry, and in LPI starts a wake; a later entry needs a fresh N ticks.
- R4: `tx_idle` = 0 while `lpi_req` = 1 makes `lpi_req` 0 one cycle later while `tx_stall` stays 1.
- R5: Once the wake begins, `tx_stall` stays 1 until M `us_tick` pulses have been counted, M = `cfg_timer[15:0]`, and falls on the next edge; M = 0 holds the stall for exactly one cycle after `lpi_req` falls.
- R6: Clearing either `cfg_lpi_en` or `cfg_auto_en` while in LPI starts a wake in the same way as R4.
- R7: `clk_gate_en` is 1 only while `lpi_req` = 1 and `cfg_gate_en` = 1, and goes to 0 in the same cycle as any wake condition (R3, R4, R6) appears on the inputs.
- R8: `stat_entry` becomes 1 on the edge where `lpi_req` rises, `stat_exit` on the edge where it falls; both hold until a cycle with `stat_rd` = 1, after which they are 0, except that an event on that same edge keeps its flag set.
- R9: `tx_stall` is 1 whenever `lpi_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_lpi_en | input | 1 | LPI enable |
| cfg_auto_en | input | 1 | Allows automatic entry when the transmit path is idle |
| cfg_link_up | input | 1 | PHY link status as reported by software |
| cfg_gate_en | input | 1 | Allows transmit clock gating while in LPI |
| cfg_timer | input | 26 | [15:0] wake time in us ticks, [25:16] link-good time in ms ticks |
| tx_idle | input | 1 | Transmit path has nothing to send |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| stat_rd | input | 1 | Software read of the status flags |
| lpi_req | output | 1 | LPI request to the PHY interface |
| tx_stall | output | 1 | Holds off the transmit data path |
| clk_gate_en | output | 1 | Transmit clock gate enable |
| stat_entry | output | 1 | Sticky LPI-entry flag |
| stat_exit | output | 1 | Sticky LPI-exit flag |

## Verification
The bench chases the timer boundaries: a link-good limit of zero, which a design with an off-by-one compare would still delay by one tick, and a wake time of zero, where a design that counted before comparing would hold the stall a cycle too long or forever. It drops the link briefly in LPI and checks that re-entry waits a full fresh count, which a design that only paused its counter would shortcut. It removes the idle indication and the arming bits in LPI to catch a clock gate that lingers one cycle after a wake, and it reads the flags on the edge of a new event to catch a clear that swallows the event.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } lpi_state_e;
endpackage

// File: rtl/eee_lpi_rst_sync.sv
module eee_lpi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-2:0], 1'b1};
  end

  assign rst_sn = pipe[STAGES-1];
endmodule

// File: rtl/eee_lpi_tick_cnt.sv
module eee_lpi_tick_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = '1;
  logic         cnt_en;
  logic [W-1:0] cnt_nxt;

  always_comb begin
    cnt_en  = clr | (tick & (cnt != MAXV));
    cnt_nxt = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end
endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm
  import eee_lpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       link_up,
  input  logic       link_ok,
  input  logic       tx_idle,
  input  logic       wake_done,
  input  logic       gate_en,
  output lpi_state_e state_o,
  output logic       lpi_req,
  output logic       tx_stall,
  output logic       clk_gate_en,
  output logic       enter_evt,
  output logic       exit_evt
);
  lpi_state_e st, st_nxt;
  logic       wake_cond;

  always_comb begin
    wake_cond = ~arm | ~link_up | ~tx_idle;
    st_nxt    = st;
    enter_evt = 1'b0;
    exit_evt  = 1'b0;
    case (st)
      ST_IDLE:  if (arm && link_up) st_nxt = ST_ARMED;
      ST_ARMED: begin
        if (!(arm && link_up)) st_nxt = ST_IDLE;
        else if (link_ok && tx_idle) begin
          st_nxt    = ST_SLEEP;
          enter_evt = 1'b1;
        end
      end
      ST_SLEEP: if (wake_cond) begin
        st_nxt   = ST_WAKE;
        exit_evt = 1'b1;
      end
      ST_WAKE:  if (wake_done) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  assign state_o     = st;
  assign lpi_req     = (st == ST_SLEEP);
  assign tx_stall    = (st == ST_SLEEP) || (st == ST_WAKE);
  assign clk_gate_en = (st == ST_SLEEP) && gate_en && !wake_cond;
endmodule

// File: rtl/eee_lpi_sticky.sv
module eee_lpi_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_o[g] <= 1'b0;
      else        flag_o[g] <= set_i[g] | (flag_o[g] & ~rd_i);
    end
  end
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
  import eee_lpi_pkg::*;
#(
  parameter int WAKE_W   = 16,
  parameter int LINK_W   = 10,
  parameter int LINK_LSB = 16,
  localparam int TIMER_W = LINK_LSB + LINK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_lpi_en,
  input  logic               cfg_auto_en,
  input  logic               cfg_link_up,
  input  logic               cfg_gate_en,
  input  logic [TIMER_W-1:0] cfg_timer,
  input  logic               tx_idle,
  input  logic               us_tick,
  input  logic               ms_tick,
  input  logic               stat_rd,
  output logic               lpi_req,
  output logic               tx_stall,
  output logic               clk_gate_en,
  output logic               stat_entry,
  output logic               stat_exit
);
  localparam int LINK_MSB = LINK_LSB + LINK_W - 1;

  logic              rst_sn;
  logic [LINK_W-1:0] link_cnt;
  logic [WAKE_W-1:0] wake_cnt;
  logic              link_ok, wake_done, enter_evt, exit_evt;
  lpi_state_e        state;
  logic [1:0]        flags;

  eee_lpi_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  eee_lpi_tick_cnt #(.W(LINK_W)) u_link_cnt (
    .clk(clk), .rst_n(rst_sn), .clr(!cfg_link_up), .tick(ms_tick), .cnt(link_cnt)
  );

  eee_lpi_tick_cnt #(.W(WAKE_W)) u_wake_cnt (
    .clk(clk), .rst_n(rst_sn), .clr(state != ST_WAKE), .tick(us_tick), .cnt(wake_cnt)
  );

  assign link_ok   = link_cnt >= cfg_timer[LINK_MSB:LINK_LSB];
  assign wake_done = wake_cnt >= cfg_timer[WAKE_W-1:0];

  eee_lpi_fsm u_fsm (
    .clk(clk), .rst_n(rst_sn),
    .arm(cfg_lpi_en & cfg_auto_en), .link_up(cfg_link_up), .link_ok(link_ok),
    .tx_idle(tx_idle), .wake_done(wake_done), .gate_en(cfg_gate_en),
    .state_o(state), .lpi_req(lpi_req), .tx_stall(tx_stall),
    .clk_gate_en(clk_gate_en), .enter_evt(enter_evt), .exit_evt(exit_evt)
  );

  eee_lpi_sticky #(.N(2)) u_flags (
    .clk(clk), .rst_n(rst_sn), .set_i({exit_evt, enter_evt}), .rd_i(stat_rd),
    .flag_o(flags)
  );

  assign stat_entry = flags[0];
  assign stat_exit  = flags[1];
endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
module eee_lpi_ctrl_chk #(
  parameter int TIMER_W = 26
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_lpi_en,
  input logic               cfg_auto_en,
  input logic               cfg_link_up,
  input logic               cfg_gate_en,
  input logic [TIMER_W-1:0] cfg_timer,
  input logic               tx_idle,
  input logic               us_tick,
  input logic               ms_tick,
  input logic               stat_rd,
  input logic               lpi_req,
  input logic               tx_stall,
  input logic               clk_gate_en,
  input logic               stat_entry,
  input logic               stat_exit
);
  p_stall_in_lpi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lpi_req |-> tx_stall);

  p_gate_needs_lpi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_gate_en |-> (lpi_req && cfg_gate_en && tx_idle && cfg_link_up));

  p_entry_guarded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpi_req) |-> ($past(cfg_lpi_en) && $past(cfg_auto_en) &&
                        $past(cfg_link_up) && $past(tx_idle)));

  p_wake_on_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_req && !tx_idle) |=> (!lpi_req && tx_stall));

  p_disarm_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_req && !(cfg_lpi_en && cfg_auto_en)) |=> !lpi_req);

  p_link_drop_wakes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_req && !cfg_link_up) |=> !lpi_req);

  p_entry_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpi_req) |-> stat_entry);

  p_exit_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lpi_req) |-> stat_exit);
endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk #(.TIMER_W(TIMER_W)) u_chk (.*);

// File: tb/eee_lpi_ctrl_bench.sv
module eee_lpi_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_lpi_en, cfg_auto_en, cfg_link_up, cfg_gate_en;
  logic [25:0] cfg_timer;
  logic        tx_idle, us_tick, ms_tick, stat_rd;
  logic        lpi_req, tx_stall, clk_gate_en, stat_entry, stat_exit;

  int vectors = 0, errors = 0, cycles = 0, tcount = 0;
  bit done = 1'b0;
  string tag = "R1";

  // behavioural reference state
  int  m_mode = 0;           // 0 off, 1 waiting, 2 asleep, 3 waking
  int  m_lcnt = 0, m_wcnt = 0;
  bit  m_fent = 0, m_fexit = 0;

  always #2 clk = ~clk;

  eee_lpi_ctrl u_eee_lpi_ctrl (.*);

  task automatic chk(input string t, input string sig, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", t, sig, act, exp, cycles);
    end
  endtask

  function automatic bit wake_cond();
    return !(cfg_lpi_en && cfg_auto_en) || !cfg_link_up || !tx_idle;
  endfunction

  task automatic model_step();
    int ls, tw, nmode;
    bit ent, ext;
    ls = int'(cfg_timer[25:16]);
    tw = int'(cfg_timer[15:0]);
    nmode = m_mode; ent = 0; ext = 0;
    case (m_mode)
      0: if (cfg_lpi_en && cfg_auto_en && cfg_link_up) nmode = 1;
      1: if (!(cfg_lpi_en && cfg_auto_en && cfg_link_up)) nmode = 0;
         else if (m_lcnt >= ls && tx_idle) begin nmode = 2; ent = 1; end
      2: if (wake_cond()) begin nmode = 3; ext = 1; end
      default: if (m_wcnt >= tw) nmode = 0;
    endcase
    if (!cfg_link_up) m_lcnt = 0;
    else if (ms_tick && m_lcnt < 1023) m_lcnt++;
    if (m_mode != 3) m_wcnt = 0;
    else if (us_tick && m_wcnt < 65535) m_wcnt++;
    m_fent  = ent | (m_fent & !stat_rd);
    m_fexit = ext | (m_fexit & !stat_rd);
    m_mode  = nmode;
  endtask

  task automatic compare();
    chk(tag, "lpi_req",     lpi_req,     m_mode == 2);
    chk(tag, "tx_stall",    tx_stall,    m_mode >= 2);
    chk(tag, "clk_gate_en", clk_gate_en, (m_mode == 2) && cfg_gate_en && !wake_cond());
    chk(tag, "stat_entry",  stat_entry,  m_fent);
    chk(tag, "stat_exit",   stat_exit,   m_fexit);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = (tcount % 5) == 4;
      us_tick = (tcount % 3) == 2;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      tcount++;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0;
    cfg_lpi_en = 0; cfg_auto_en = 0; cfg_link_up = 0; cfg_gate_en = 0;
    cfg_timer = {10'd3, 16'd4};
    tx_idle = 1; us_tick = 0; ms_tick = 0; stat_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "lpi_req", lpi_req, 1'b0);
    chk("R1", "tx_stall", tx_stall, 1'b0);
    chk("R1", "clk_gate_en", clk_gate_en, 1'b0);
    chk("R1", "stat_entry", stat_entry, 1'b0);
    chk("R1", "stat_exit", stat_exit, 1'b0);

    // R2: armed entry after the link-good count
    tag = "R2";
    cfg_lpi_en = 1; cfg_auto_en = 1; cfg_link_up = 1; cfg_gate_en = 1;
    cyc(40);
    chk("R2", "lpi_req", lpi_req, 1'b1);
    chk("R9", "tx_stall", tx_stall, 1'b1);
    chk("R7", "clk_gate_en", clk_gate_en, 1'b1);
    chk("R8", "stat_entry", stat_entry, 1'b1);

    // R4/R7: traffic wakes the link, gate drops at once
    tag = "R4";
    tx_idle = 0;
    #0 chk("R7", "clk_gate_en", clk_gate_en, 1'b0);
    cyc(1);
    chk("R4", "lpi_req", lpi_req, 1'b0);
    chk("R4", "tx_stall", tx_stall, 1'b1);
    tag = "R5";
    cyc(30);
    chk("R5", "tx_stall", tx_stall, 1'b0);
    chk("R8", "stat_exit", stat_exit, 1'b1);

    // R8: read clears the flags
    tag = "R8";
    stat_rd = 1; cyc(1); stat_rd = 0;
    chk("R8", "stat_entry", stat_entry, 1'b0);
    chk("R8", "stat_exit", stat_exit, 1'b0);

    // R6: disarming wakes the link
    tag = "R6";
    tx_idle = 1; cyc(5);
    chk("R6", "lpi_req", lpi_req, 1'b1);
    // R8: read on the edge of a new event keeps that flag
    cfg_auto_en = 0; stat_rd = 1; cyc(1); stat_rd = 0;
    chk("R6", "lpi_req", lpi_req, 1'b0);
    chk("R8", "stat_exit", stat_exit, 1'b1);
    cyc(25);
    cfg_auto_en = 1;
    cyc(10);
    chk("R6", "lpi_req", lpi_req, 1'b1);

    // R3: link drop restarts the count
    tag = "R3";
    cfg_link_up = 0; cyc(2);
    cfg_link_up = 1; cyc(3);
    chk("R3", "lpi_req", lpi_req, 1'b0);
    cyc(40);
    chk("R3", "lpi_req", lpi_req, 1'b1);

    // R7: no gating when gating is not allowed
    tag = "R7";
    cfg_gate_en = 0; cyc(5);
    chk("R7", "clk_gate_en", clk_gate_en, 1'b0);
    cfg_gate_en = 1;

    // R5: zero limits
    tag = "R5";
    cfg_timer = '0;
    tx_idle = 0; cyc(20);
    tx_idle = 1; cyc(3);
    chk("R2", "lpi_req", lpi_req, 1'b1);
    tx_idle = 0; cyc(1);
    chk("R5", "tx_stall", tx_stall, 1'b1);
    cyc(1);
    chk("R5", "tx_stall", tx_stall, 1'b0);

    // mixed traffic against the model
    tag = "R2";
    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tx_idle     = lf[2:0] != 3'd0;
      cfg_link_up = lf[7:4] != 4'd0;
      stat_rd     = lf[9] & lf[8];
      cfg_auto_en = lf[11:10] != 2'd0;
      cfg_gate_en = lf[12];
      if (lf[15:13] == 3'd0) cfg_timer = {8'd0, lf[1:0], 14'd0, lf[5:4]};
      cyc(1);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule